// File: doc/BRIEF.md
# Configurable registered command buffer

This block sits on the command and address path of a memory module. It registers a group of input bits on each rising clock edge and drives the result onto an output pin bus. Two static configuration inputs pick the pin mapping. In the straight mode all 25 input lanes reach 25 output pins one for one. In the duplicating mode 14 input lanes are captured and each one drives a pair of adjacent pins. A second configuration input chooses which 14 lanes are used, so that two instances together can cover the whole input group.

Alongside the data the block drives a parity bit. This bit is the XOR of the input lanes that the current mode carries, and it is registered in step with the data. Two active-low chip-select inputs control a low-power hold. When both are inactive (high) at a clock edge, the data pins and the parity bit keep their values and do not toggle. The chip selects themselves are always registered and passed through. An active-low reset clears everything at once and forces every output low. Its release is synchronised to the clock.

Top module: `cmd_reg_buffer`

## Requirements
- R1: While `rst_n` is low, `pin_o`, `ppo_o`, `cs_a_n_o` and `cs_b_n_o` are all 0, and they reach 0 at once when reset is asserted, without waiting for a clock edge.
- R2: Reset release is synchronous. After `rst_n` rises, the outputs stay 0 through the first two rising edges, and the third rising edge captures the inputs.
- R3: With `cfg_dup` = 0 (straight mode), `pin_o[p]` for p = 0..24 equals `data_i[p]` as captured at the previous rising edge.
- R4: In straight mode the spare pins `pin_o[27:25]` are always 0.
- R5: With `cfg_dup` = 1 and `cfg_upper` = 0, both `pin_o[2k]` and `pin_o[2k+1]` equal captured `data_i[k]`, for k = 0..13.
- R6: With `cfg_dup` = 1 and `cfg_upper` = 1, both `pin_o[2k]` and `pin_o[2k+1]` equal captured `data_i[11+k]`, for k = 0..13.
- R7: `ppo_o` is the XOR of the captured lanes the mode carries: all of `data_i[24:0]` in straight mode, `data_i[13:0]` in low duplicating mode, `data_i[24:11]` in high duplicating mode. It updates in the same cycle as `pin_o`.
- R8: When `cs_a_n_i` and `cs_b_n_i` are both 1 at a rising edge, `pin_o` and `ppo_o` keep their previous values.
- R9: When either chip-select input is 0 at a rising edge, `pin_o` and `ppo_o` update from `data_i`.
- R10: `cs_a_n_o` and `cs_b_n_o` equal `cs_a_n_i` and `cs_b_n_i` from the previous rising edge, including during a hold.
- R11: Reset takes priority over the hold. Asserting `rst_n` low while both chip selects are high still clears `pin_o` and `ppo_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cfg_dup | input | 1 | Static mode select: 0 = straight 25-bit, 1 = duplicating 14-bit |
| cfg_upper | input | 1 | Static lane-group select in duplicating mode: 0 = lanes 0..13, 1 = lanes 11..24 |
| data_i | input | 25 | Command and address input lanes |
| cs_a_n_i | input | 1 | Chip select A, active low |
| cs_b_n_i | input | 1 | Chip select B, active low |
| pin_o | output | 28 | Registered output pin bus |
| ppo_o | output | 1 | Registered parity of the carried lanes |
| cs_a_n_o | output | 1 | Registered chip select A |
| cs_b_n_o | output | 1 | Registered chip select B |

## Verification
The assertions assume that `cfg_dup` and `cfg_upper` are static levels that change only while `rst_n` is low. They also assume `rst_n` has been high for three consecutive sampled edges before any data-path comparison is made. The stimulus respects both assumptions. Every test task begins by asserting reset, setting the configuration while reset is held, and releasing reset at a falling edge. Data and chip-select changes are then made only at falling edges.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [1:0] {
        MODE_STRAIGHT = 2'd0,
        MODE_DUP_LOW  = 2'd1,
        MODE_DUP_HIGH = 2'd2
    } map_mode_e;

    // Static configuration pins to pin-mapping mode.
    function automatic map_mode_e decode_mode(input logic dup, input logic upper);
        if (!dup) begin
            return MODE_STRAIGHT;
        end
        return upper ? MODE_DUP_HIGH : MODE_DUP_LOW;
    endfunction

endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_i,
    output logic rst_n_o
);
    // Asynchronous assert, synchronous release.
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cmdbuf_lane_map.sv
module cmdbuf_lane_map
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W     = 25,
    parameter int HALF_W     = 14,
    parameter int OUT_W      = 2 * HALF_W,
    parameter int UPPER_BASE = DATA_W - HALF_W
) (
    input  map_mode_e         mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [OUT_W-1:0]  pins_o
);
    for (genvar p = 0; p < OUT_W; p++) begin : g_pin
        localparam int LANE_LO = p / 2;
        localparam int LANE_HI = UPPER_BASE + (p / 2);
        logic straight_bit;
        logic pin_bit;

        if (p < DATA_W) begin : g_live
            assign straight_bit = data_i[p];
        end else begin : g_spare
            assign straight_bit = 1'b0;
        end

        always_comb begin
            unique case (mode_i)
                MODE_STRAIGHT: pin_bit = straight_bit;
                MODE_DUP_LOW:  pin_bit = data_i[LANE_LO];
                MODE_DUP_HIGH: pin_bit = data_i[LANE_HI];
                default:       pin_bit = 1'b0;
            endcase
        end

        assign pins_o[p] = pin_bit;
    end
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W     = 25,
    parameter int HALF_W     = 14,
    parameter int UPPER_BASE = DATA_W - HALF_W
) (
    input  map_mode_e         mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              par_o
);
    localparam logic [DATA_W-1:0] ALL_MASK  = '1;
    localparam logic [DATA_W-1:0] LOW_MASK  = ALL_MASK >> (DATA_W - HALF_W);
    localparam logic [DATA_W-1:0] HIGH_MASK = LOW_MASK << UPPER_BASE;

    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (mode_i)
            MODE_STRAIGHT: mask = ALL_MASK;
            MODE_DUP_LOW:  mask = LOW_MASK;
            MODE_DUP_HIGH: mask = HIGH_MASK;
            default:       mask = '0;
        endcase
    end

    assign par_o = ^(data_i & mask);
endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W = 25,
    parameter int HALF_W = 14,
    localparam int OUT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dup,
    input  logic              cfg_upper,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cs_a_n_i,
    input  logic              cs_b_n_i,
    output logic [OUT_W-1:0]  pin_o,
    output logic              ppo_o,
    output logic              cs_a_n_o,
    output logic              cs_b_n_o
);
    localparam int UPPER_BASE = DATA_W - HALF_W;

    typedef struct packed {
        logic [OUT_W-1:0] pins;
        logic             par;
        logic             cs_a_n;
        logic             cs_b_n;
    } state_t;

    state_t           st_d, st_q;
    logic             rst_sync_n;
    map_mode_e        mode;
    logic [OUT_W-1:0] map_pins;
    logic             map_par;
    logic             hold;

    cmdbuf_rst_sync #(.STAGES(2)) u_rst_sync (
        .clk     (clk),
        .rst_n_i (rst_n),
        .rst_n_o (rst_sync_n)
    );

    assign mode = decode_mode(cfg_dup, cfg_upper);

    cmdbuf_lane_map #(
        .DATA_W     (DATA_W),
        .HALF_W     (HALF_W),
        .OUT_W      (OUT_W),
        .UPPER_BASE (UPPER_BASE)
    ) u_lane_map (
        .mode_i (mode),
        .data_i (data_i),
        .pins_o (map_pins)
    );

    cmdbuf_parity #(
        .DATA_W     (DATA_W),
        .HALF_W     (HALF_W),
        .UPPER_BASE (UPPER_BASE)
    ) u_parity (
        .mode_i (mode),
        .data_i (data_i),
        .par_o  (map_par)
    );

    // Both selects inactive: freeze the data path.
    assign hold = cs_a_n_i & cs_b_n_i;

    always_comb begin
        st_d        = st_q;
        st_d.cs_a_n = cs_a_n_i;
        st_d.cs_b_n = cs_b_n_i;
        if (!hold) begin
            st_d.pins = map_pins;
            st_d.par  = map_par;
        end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o    = st_q.pins;
    assign ppo_o    = st_q.par;
    assign cs_a_n_o = st_q.cs_a_n;
    assign cs_b_n_o = st_q.cs_b_n;
endmodule

// File: rtl/cmd_reg_buffer_chk.sv
module cmd_reg_buffer_chk #(
    parameter int DATA_W = 25,
    parameter int HALF_W = 14,
    parameter int OUT_W  = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dup,
    input logic              cfg_upper,
    input logic [DATA_W-1:0] data_i,
    input logic              cs_a_n_i,
    input logic              cs_b_n_i,
    input logic [OUT_W-1:0]  pin_o,
    input logic              ppo_o,
    input logic              cs_a_n_o,
    input logic              cs_b_n_o
);
    localparam int UB = DATA_W - HALF_W;

    logic [HALF_W-1:0] even_v, odd_v;
    always_comb begin
        for (int k = 0; k < HALF_W; k++) begin
            even_v[k] = pin_o[2*k];
            odd_v[k]  = pin_o[2*k+1];
        end
    end

    logic idle_sel;
    assign idle_sel = cs_a_n_i & cs_b_n_i;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (pin_o == '0 && !ppo_o && !cs_a_n_o && !cs_b_n_o));

    // R11
    hold_reset_chk: assert property (@(posedge clk)
        (!rst_n && idle_sel) |-> (pin_o == '0 && !ppo_o));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_sel |=> ($stable(pin_o) && $stable(ppo_o)));

    // R10
    cs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2))
        |=> (cs_a_n_o == $past(cs_a_n_i) && cs_b_n_o == $past(cs_b_n_i)));

    // R3
    straight_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2) && !cfg_dup && !idle_sel)
        |=> (pin_o[DATA_W-1:0] == $past(data_i)));

    // R7
    straight_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2) && !cfg_dup && !idle_sel)
        |=> (ppo_o == ^$past(data_i)));

    if (OUT_W > DATA_W) begin : g_spare_chk
        // R4
        spare_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_dup |-> (pin_o[OUT_W-1:DATA_W] == '0));
    end

    // R5
    dup_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dup |-> (even_v == odd_v));

    // R5
    dup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2) && cfg_dup && !cfg_upper && !idle_sel)
        |=> (even_v == $past(data_i[HALF_W-1:0])));

    // R6
    dup_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2) && cfg_dup && cfg_upper && !idle_sel)
        |=> (even_v == $past(data_i[UB +: HALF_W])));
endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_dup   (cfg_dup),
    .cfg_upper (cfg_upper),
    .data_i    (data_i),
    .cs_a_n_i  (cs_a_n_i),
    .cs_b_n_i  (cs_b_n_i),
    .pin_o     (pin_o),
    .ppo_o     (ppo_o),
    .cs_a_n_o  (cs_a_n_o),
    .cs_b_n_o  (cs_b_n_o)
);

// File: tb/tb_cmd_reg_buffer.sv
module tb_cmd_reg_buffer;
    localparam int DW = 25;
    localparam int HW = 14;
    localparam int OW = 2 * HW;
    localparam int UB = DW - HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_dup = 1'b0;
    logic          cfg_upper = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic          cs_a_n_i = 1'b1;
    logic          cs_b_n_i = 1'b1;
    logic [OW-1:0] pin_o;
    logic          ppo_o;
    logic          cs_a_n_o;
    logic          cs_b_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmd_reg_buffer #(.DATA_W(DW), .HALF_W(HW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_dup   (cfg_dup),
        .cfg_upper (cfg_upper),
        .data_i    (data_i),
        .cs_a_n_i  (cs_a_n_i),
        .cs_b_n_i  (cs_b_n_i),
        .pin_o     (pin_o),
        .ppo_o     (ppo_o),
        .cs_a_n_o  (cs_a_n_o),
        .cs_b_n_o  (cs_b_n_o)
    );

    function automatic logic [OW-1:0] exp_pins(input logic [DW-1:0] d, input logic dup, input logic up);
        logic [OW-1:0] r = '0;
        for (int p = 0; p < OW; p++) begin
            if (!dup) r[p] = (p < DW) ? d[p] : 1'b0;
            else      r[p] = up ? d[UB + p/2] : d[p/2];
        end
        return r;
    endfunction

    function automatic logic exp_par(input logic [DW-1:0] d, input logic dup, input logic up);
        logic r = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (!dup || (!up && i < HW) || (up && i >= UB)) r ^= d[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_zero(input string tag);
        check(tag, {pin_o, ppo_o, cs_a_n_o, cs_b_n_o}, 64'd0);
    endtask

    task automatic check_data(input string tag, input logic [DW-1:0] d);
        check({tag, " pins"}, 64'(pin_o), 64'(exp_pins(d, cfg_dup, cfg_upper)));
        check("R7 parity", 64'(ppo_o), 64'(exp_par(d, cfg_dup, cfg_upper)));
    endtask

    task automatic drive(input logic [DW-1:0] d, input logic a, input logic b);
        data_i   = d;
        cs_a_n_i = a;
        cs_b_n_i = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic dup, input logic up);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_zero("R1 reset forces outputs low");
        cfg_dup   = dup;
        cfg_upper = up;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_release();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dup = 1'b0;
        cfg_upper = 1'b0;
        @(negedge clk);
        check_zero("R1 reset held");
        rst_n = 1'b1;
        data_i = 25'h1ABCDEF;
        cs_a_n_i = 1'b0;
        cs_b_n_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check_zero("R2 first edge after release");
        @(posedge clk); @(negedge clk);
        check_zero("R2 second edge after release");
        @(posedge clk); @(negedge clk);
        check_data("R2 third edge captures", 25'h1ABCDEF);
    endtask

    task automatic t_straight();
        logic [DW-1:0] pats [4] = '{25'h1555555, 25'h0AAAAAA, 25'h1FFFFFF, 25'h0000001};
        start(1'b0, 1'b0);
        foreach (pats[i]) begin
            drive(pats[i], 1'b0, 1'b0);
            check_data("R3 straight", pats[i]);
            check("R4 spare pins", 64'(pin_o[OW-1:DW]), 64'd0);
        end
    endtask

    task automatic t_dup(input logic up);
        logic [DW-1:0] pats [3] = '{25'h0003FFF, 25'h1FFC000, 25'h0A5C3E1};
        start(1'b1, up);
        foreach (pats[i]) begin
            drive(pats[i], 1'b0, 1'b1);
            if (up) check_data("R6 dup high", pats[i]);
            else    check_data("R5 dup low", pats[i]);
        end
    endtask

    task automatic t_hold();
        start(1'b0, 1'b0);
        drive(25'h0123456, 1'b0, 1'b0);
        check_data("R9 both selected", 25'h0123456);
        drive(25'h1FEDCBA, 1'b1, 1'b1);
        check_data("R8 hold keeps previous", 25'h0123456);
        check("R10 cs pass during hold", 64'({cs_a_n_o, cs_b_n_o}), 64'd3);
        drive(25'h0F0F0F0, 1'b1, 1'b1);
        check_data("R8 hold second cycle", 25'h0123456);
        drive(25'h1333333, 1'b1, 1'b0);
        check_data("R9 cs_b selects", 25'h1333333);
        check("R10 cs pass", 64'({cs_a_n_o, cs_b_n_o}), 64'd2);
        drive(25'h0444444, 1'b0, 1'b1);
        check_data("R9 cs_a selects", 25'h0444444);
        check("R10 cs pass", 64'({cs_a_n_o, cs_b_n_o}), 64'd1);
    endtask

    task automatic t_reset_prio();
        start(1'b0, 1'b0);
        drive(25'h1FFFFFF, 1'b0, 1'b0);
        drive(25'h0000000, 1'b1, 1'b1);
        check_data("R8 hold before reset", 25'h1FFFFFF);
        rst_n = 1'b0;
        #1;
        check("R11 reset overrides hold", 64'({pin_o, ppo_o}), 64'd0);
        @(negedge clk);
        check_zero("R1 reset during hold");
    endtask

    initial begin
        #(50000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check_zero("R1 initial reset state");
        t_release();
        t_straight();
        t_dup(1'b0);
        t_dup(1'b1);
        t_hold();
        t_reset_prio();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule